// File: doc/BRIEF.md
# Programmable Color Matrix Converter

The block converts a stream of 10-bit-per-channel pixels through a programmable 3x3 matrix. For each channel it first adds a signed input offset to the component. It then forms three weighted sums with signed fixed-point coefficients and rounds and scales each sum back down. Next it adds a signed output offset and saturates the result to the 10-bit range. A typical load is an RGB to limited-range YCbCr matrix: zero input offsets and output offsets of 64, 512 and 512.

Settings arrive through a simple write-only word port into a pending register bank. The active settings that the pipeline uses are replaced by the pending copy only when a frame-start strobe is given. This keeps each frame consistent. When conversion is off, pixels travel through the same three pipeline stages unchanged, so the latency is the same in both cases. The stream accepts one pixel per clock with a valid qualifier and no backpressure.

Top module: `csc_matrix`

## Requirements
- R1: After reset, outValid is low and outPixel is zero. All settings are zero, so conversion is disabled.
- R2: Every pixel accepted with inValid high appears on outPixel with outValid high exactly 3 cycles later, whether converted or bypassed. outPixel holds its value in cycles where outValid is low.
- R3: While bit 0 of the active control word (word 9) is clear, outPixel equals the input pixel unchanged.
- R4: The control word carries a mode field in bits 31:30. Only mode 0 converts; any other mode passes pixels through unchanged, even when the enable bit is set.
- R5: Coefficients are 13-bit two's complement with 1.0 encoded as 1024. They are packed two per word in row-major order: word 2 holds c00 in bits 28:16 and c01 in bits 12:0, word 3 holds c02/c10, word 4 holds c11/c12, word 5 holds c20/c21, and word 6 holds c22 in bits 28:16. Pixel channel 0 is bits 29:20, channel 1 is bits 19:10 and channel 2 is bits 9:0, on both input and output.
- R6: Input offsets are 12-bit two's complement. Word 0 holds offset 0 in bits 27:16 and offset 1 in bits 11:0, and word 1 holds offset 2 in bits 11:0. Each offset is added to its component before the multiply.
- R7: Each output is ((sum over c of coef[r][c] * (in[c] + pre[c])) + 512) shifted arithmetically right by 10 plus the shift field. The shift field is bits 18:16 of the control word.
- R8: Output offsets are 12-bit two's complement and use the same layout as the input offsets, in words 7 and 8. Each is added after the shift, and the result saturates to 0 for negative values and to 1023 above that.
- R9: Writes change only the pending settings. The active settings take the pending values at a frameStart pulse. A write in the same cycle as frameStart reaches the active settings only at the next frameStart.
- R10: Pixels presented on consecutive cycles are all converted, one per clock, with no gaps inserted.
- R11: Writes to word addresses 10 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Setting write strobe |
| regAddr | input | 4 | Setting word address |
| regWrData | input | 32 | Setting word data |
| frameStart | input | 1 | Copies pending settings to active settings |
| inValid | input | 1 | Input pixel qualifier |
| inPixel | input | 30 | Input pixel, three 10-bit channels |
| outValid | output | 1 | Output pixel qualifier |
| outPixel | output | 30 | Output pixel, three 10-bit channels |

## Verification
The hardest case to reach from the ports is the boundary between the pending and active banks. A write that lands in the same cycle as the frame strobe must miss that frame's settings, and a write during a frame must leave the pixels of that frame alone. The stimulus drives a control-word write and the frame strobe in one cycle, then streams pixels and checks that conversion still follows the older settings. A later strobe alone must then switch the stream to bypass. Saturation at both ends is reached by loading gains near the 13-bit limit and negative unity gains, and the right-shift field is exercised with a shift of two on a full matrix.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CHW   = 10;
  localparam int NCH   = 3;
  localparam int PIXW  = CHW * NCH;
  localparam int COEFW = 13;
  localparam int OFFW  = 12;
  localparam int FRAC  = 10;
  localparam int SHW   = 3;
  localparam int MODEW = 2;
  localparam int ADDRW = 4;
  localparam int DATAW = 32;
  localparam int NCOEF = NCH * NCH;
  localparam int STAGES = 3;
  localparam int SUMW  = CHW + 3;
  localparam int ACCW  = SUMW + COEFW + $clog2(NCH);

  localparam int A_PRE   = 0;
  localparam int A_COEF  = 2;
  localparam int A_POST  = 7;
  localparam int A_CTRL  = 9;

  typedef struct packed {
    logic [NCOEF-1:0][COEFW-1:0] coef;
    logic [NCH-1:0][OFFW-1:0]    pre;
    logic [NCH-1:0][OFFW-1:0]    post;
    logic [SHW-1:0]              shift;
    logic [MODEW-1:0]            mode;
    logic                        enable;
  } cscCfgT;

  typedef struct packed {
    logic adv1;
    logic adv2;
    logic adv3;
    logic conv;
  } cscStrobeT;
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [DATAW-1:0] regWrData,
  input  logic             frameStart,
  input  logic             inValid,
  output cscCfgT           activeCfg,
  output cscStrobeT        strobe,
  output logic             outValid
);
  cscCfgT pendCfg;
  cscCfgT nextPend;
  logic [STAGES-1:0] validPipe;
  logic unusedData;

  assign unusedData = ^regWrData;

  // Decode one word write into the pending bank
  always_comb begin
    nextPend = pendCfg;
    if (regWrEn) begin
      for (int k = 0; k < NCOEF; k++) begin
        if (regAddr == ADDRW'(A_COEF + k / 2))
          nextPend.coef[k] = (k % 2 == 0) ? regWrData[16 +: COEFW] : regWrData[0 +: COEFW];
      end
      for (int i = 0; i < NCH; i++) begin
        if (regAddr == ADDRW'(A_PRE + i / 2))
          nextPend.pre[i] = ((i % 2 == 0) && (i != NCH - 1)) ? regWrData[16 +: OFFW]
                                                             : regWrData[0 +: OFFW];
        if (regAddr == ADDRW'(A_POST + i / 2))
          nextPend.post[i] = ((i % 2 == 0) && (i != NCH - 1)) ? regWrData[16 +: OFFW]
                                                              : regWrData[0 +: OFFW];
      end
      if (regAddr == ADDRW'(A_CTRL)) begin
        nextPend.enable = regWrData[0];
        nextPend.shift  = regWrData[16 +: SHW];
        nextPend.mode   = regWrData[30 +: MODEW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg   <= '0;
      activeCfg <= '0;
      validPipe <= '0;
    end else begin
      if (frameStart) activeCfg <= pendCfg;
      pendCfg   <= nextPend;
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  assign strobe.adv1 = inValid;
  assign strobe.adv2 = validPipe[0];
  assign strobe.adv3 = validPipe[1];
  assign strobe.conv = activeCfg.enable && (activeCfg.mode == '0);
  assign outValid    = validPipe[STAGES-1];
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  cscCfgT          cfg,
  input  cscStrobeT       strobe,
  input  logic [PIXW-1:0] inPixel,
  output logic [PIXW-1:0] outPixel
);
  localparam int RW = ACCW + 2;
  localparam logic signed [RW-1:0] HALF = RW'(1 << (FRAC - 1));
  localparam int MAXV = (1 << CHW) - 1;

  logic [NCH-1:0][SUMW-1:0] preSum, s1Sum;
  logic [NCH-1:0][ACCW-1:0] rowAcc, s2Acc;
  logic [PIXW-1:0] s1Pix, s2Pix, outNext;
  logic s1Conv, s2Conv;
  logic unusedCfg;

  assign unusedCfg = ^{cfg.mode, cfg.enable};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_pre
    localparam int LSB = (NCH - 1 - ch) * CHW;
    assign preSum[ch] = SUMW'($signed({1'b0, inPixel[LSB +: CHW]})) + SUMW'($signed(cfg.pre[ch]));
  end

  for (genvar r = 0; r < NCH; r++) begin : g_row
    logic signed [ACCW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int c = 0; c < NCH; c++)
        acc = acc + ACCW'($signed(cfg.coef[r * NCH + c])) * ACCW'($signed(s1Sum[c]));
    end
    assign rowAcc[r] = acc;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_out
    localparam int LSB = (NCH - 1 - ch) * CHW;
    logic signed [RW-1:0] biased, shifted, withPost;
    logic [CHW-1:0] clipped;
    always_comb begin
      biased   = RW'($signed(s2Acc[ch])) + HALF;
      shifted  = biased >>> (FRAC + int'(cfg.shift));
      withPost = shifted + RW'($signed(cfg.post[ch]));
      if (withPost[RW-1])                clipped = '0;
      else if (|withPost[RW-2:CHW])      clipped = CHW'(MAXV);
      else                               clipped = withPost[CHW-1:0];
    end
    assign outNext[LSB +: CHW] = clipped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Sum <= '0; s1Pix <= '0; s1Conv <= 1'b0;
      s2Acc <= '0; s2Pix <= '0; s2Conv <= 1'b0;
      outPixel <= '0;
    end else begin
      if (strobe.adv1) begin
        s1Sum <= preSum; s1Pix <= inPixel; s1Conv <= strobe.conv;
      end
      if (strobe.adv2) begin
        s2Acc <= rowAcc; s2Pix <= s1Pix; s2Conv <= s1Conv;
      end
      if (strobe.adv3)
        outPixel <= s2Conv ? outNext : s2Pix;
    end
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [DATAW-1:0] regWrData,
  input  logic             frameStart,
  input  logic             inValid,
  input  logic [PIXW-1:0]  inPixel,
  output logic             outValid,
  output logic [PIXW-1:0]  outPixel
);
  cscCfgT    activeCfg;
  cscStrobeT strobe;

  csc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart), .inValid(inValid),
    .activeCfg(activeCfg), .strobe(strobe), .outValid(outValid)
  );

  csc_datapath i_dp (
    .clk(clk), .rstN(rstN), .cfg(activeCfg), .strobe(strobe),
    .inPixel(inPixel), .outPixel(outPixel)
  );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
  import csc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            frameStart,
  input logic            inValid,
  input logic [PIXW-1:0] inPixel,
  input logic            outValid,
  input logic [PIXW-1:0] outPixel,
  input cscCfgT          activeCfg
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3) |-> (outValid == $past(inValid, 3)));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && !outValid) |-> $stable(outPixel));

  // R3 R4
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3 && outValid &&
     !($past(activeCfg.enable, 3) && $past(activeCfg.mode, 3) == 2'd0))
    |-> (outPixel == $past(inPixel, 3)));

  // R9
  cfg_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && !$past(frameStart)) |-> $stable(activeCfg));
endmodule

bind csc_matrix csc_matrix_chk i_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .inValid(inValid),
  .inPixel(inPixel), .outValid(outValid), .outPixel(outPixel),
  .activeCfg(activeCfg)
);

// File: tb/test_csc_matrix.sv
module test_csc_matrix;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic frameStart = 1'b0;
  logic inValid = 1'b0;
  logic [29:0] inPixel = '0;
  logic outValid;
  logic [29:0] outPixel;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  int pend[10];
  int act[10];
  bit expV[3];
  logic [29:0] expP[3];
  int seed = 7;
  bit done = 0;

  always #10 clk = ~clk;

  csc_matrix i_csc_matrix (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart), .inValid(inValid),
    .inPixel(inPixel), .outValid(outValid), .outPixel(outPixel)
  );

  function automatic int sx(int v, int w);
    return ((v >> (w - 1)) & 1) ? v - (1 << w) : v;
  endfunction

  function automatic int pack2(int a, int b);
    return ((a & 'h1fff) << 16) | (b & 'h1fff);
  endfunction

  function automatic logic [29:0] refPix(logic [29:0] p);
    int pre[3], post[3], cf[9], sh, acc, v;
    logic [29:0] res;
    if (!(act[9] & 1) || (((act[9] >> 30) & 3) != 0)) return p;
    pre[0] = sx((act[0] >> 16) & 'hfff, 12); pre[1] = sx(act[0] & 'hfff, 12);
    pre[2] = sx(act[1] & 'hfff, 12);
    post[0] = sx((act[7] >> 16) & 'hfff, 12); post[1] = sx(act[7] & 'hfff, 12);
    post[2] = sx(act[8] & 'hfff, 12);
    for (int k = 0; k < 9; k++)
      cf[k] = sx((k % 2 == 0) ? ((act[2 + k / 2] >> 16) & 'h1fff) : (act[2 + k / 2] & 'h1fff), 13);
    sh = (act[9] >> 16) & 7;
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int c = 0; c < 3; c++)
        acc += cf[r * 3 + c] * (int'(p[(2 - c) * 10 +: 10]) + pre[c]);
      v = ((acc + 512) >>> (10 + sh)) + post[r];
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      res[(2 - r) * 10 +: 10] = v[9:0];
    end
    return res;
  endfunction

  // Behavioural reference: three-deep expected queue and two setting banks
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 10; i++) begin pend[i] = 0; act[i] = 0; end
      for (int i = 0; i < 3; i++) begin expV[i] = 0; expP[i] = '0; end
    end else begin
      expV[2] = expV[1]; expP[2] = expP[1];
      expV[1] = expV[0]; expP[1] = expP[0];
      expV[0] = inValid; expP[0] = refPix(inPixel);
      if (frameStart) act = pend;
      if (regWrEn && regAddr < 10) pend[regAddr] = regWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (outValid !== expV[2]) begin
        fails++;
        $display("FAIL R2: outValid actual %b expected %b", outValid, expV[2]);
      end
      if (expV[2] && outValid) begin
        checks++;
        if (outPixel !== expP[2]) begin
          fails++;
          $display("FAIL %s: outPixel actual %h expected %h", curReq, outPixel, expP[2]);
        end
      end
    end
  end

  task automatic drive(bit v, logic [29:0] p, bit we, int a, int d, bit fs);
    @(negedge clk);
    inValid = v; inPixel = p; regWrEn = we; regAddr = a[3:0]; regWrData = d; frameStart = fs;
  endtask

  task automatic wr(int a, int d);
    drive(0, '0, 1, a, d, 0);
  endtask

  task automatic commit();
    repeat (3) drive(0, '0, 0, 0, 0, 0);
    drive(0, '0, 0, 0, 0, 1);
  endtask

  task automatic stream(int n, bit gaps);
    logic [29:0] px;
    for (int i = 0; i < n; i++) begin
      seed = seed * 1103515245 + 12345;
      case (i)
        0: px = '0;
        1: px = 30'h3fffffff;
        2: px = {10'd1023, 20'd0};
        3: px = {10'd0, 10'd1023, 10'd0};
        default: px = 30'(seed >> 1);
      endcase
      drive(gaps ? ((seed >> 7) & 1) != 0 : 1'b1, px, 0, 0, 0, 0);
    end
    repeat (4) drive(0, '0, 0, 0, 0, 0);
  endtask

  task automatic loadMatrix(int c00, int c01, int c02, int c10, int c11, int c12,
                            int c20, int c21, int c22);
    wr(2, pack2(c00, c01)); wr(3, pack2(c02, c10)); wr(4, pack2(c11, c12));
    wr(5, pack2(c20, c21)); wr(6, pack2(c22, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    curReq = "R1";
    checks++;
    if (outValid !== 1'b0 || outPixel !== '0) begin
      fails++;
      $display("FAIL R1: out actual %b/%h expected 0/0", outValid, outPixel);
    end
    // R3 disabled after reset passes pixels through
    curReq = "R3";
    stream(20, 1);
    // R5 identity gains, still pending until strobe (R9)
    loadMatrix(1024, 0, 0, 0, 1024, 0, 0, 0, 1024);
    wr(9, 1);
    curReq = "R9";
    stream(10, 0);
    commit();
    curReq = "R5";
    stream(30, 1);
    // R11 unused words ignored
    wr(12, -1); wr(15, -1); wr(10, 0);
    curReq = "R11";
    stream(20, 1);
    // R7 limited-range YCbCr matrix with output offsets, then shift of two
    loadMatrix(186, 627, 63, -103, -345, 448, 448, -407, -41);
    wr(7, (64 << 16) | 512); wr(8, 512);
    commit();
    curReq = "R7";
    stream(40, 1);
    wr(9, 1 | (2 << 16));
    commit();
    stream(20, 0);
    // R6 negative and positive input offsets
    loadMatrix(1024, 0, 0, 0, 1024, 0, 0, 512, 512);
    wr(0, ((-300 & 'hfff) << 16) | 200); wr(1, -1000 & 'hfff);
    wr(7, 0); wr(8, 0); wr(9, 1);
    commit();
    curReq = "R6";
    stream(30, 1);
    // R8 saturation at both ends
    wr(0, 0); wr(1, 0);
    loadMatrix(4095, 0, 0, 0, -1024, 0, 0, 0, 1024);
    wr(8, -2000 & 'hfff); wr(7, (100 << 16) | 300);
    commit();
    curReq = "R8";
    stream(30, 1);
    // R10 back-to-back throughput
    curReq = "R10";
    stream(50, 0);
    // R4 non-zero mode bypasses
    wr(9, 1 | (1 << 30));
    commit();
    curReq = "R4";
    stream(20, 1);
    // R9 write in the same cycle as the strobe stays pending
    wr(9, 1);
    repeat (3) drive(0, '0, 0, 0, 0, 0);
    drive(0, '0, 1, 9, 0, 1);
    curReq = "R9";
    stream(20, 1);
    commit();
    curReq = "R3";
    stream(20, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule